// File: doc/BRIEF.md
# UART Channel Interrupt Controller

This block decides when one serial channel interrupts the host and reports which cause is the most urgent. It holds an 8-bit enable register. It also watches the channel's status and event signals: receive FIFO level against its trigger, transmit FIFO level against its trigger, holding-register state, byte error flags, a modem-change pulse, a received-Xoff pulse, and the two flow-control pins. From these it drives a single interrupt line and an encoded status byte.

The host reaches both registers through a small port. A select bit picks the register: 0 is the enable register and 1 is the status register. A write strobe and a read strobe go with the select bit. Reading the status register acknowledges the latched cause it reports. A separate strobe marks writes into the transmit holding register.

Top module: `uart_irq_ctrl`

## Requirements
- R1: With enable bit 0 set, the receive cause (status 0x04) is active when the FIFO is off and `rhr_full` is 1, or when the FIFO is on and `rx_level >= rx_trig`. Both the line and the status follow the inputs in the same cycle.
- R2: In FIFO mode the receive cause drops by itself as soon as `rx_level` falls below `rx_trig`. No host access is needed.
- R3: With enable bit 1 set, the transmit cause (status 0x02) is latched one cycle after one of two events. The first is the transmit condition rising: `thr_empty` without the FIFO, or `tx_level < tx_trig` with the FIFO. The second is enable bit 1 being written from 0 to 1 while the condition already holds. The cause clears on a `thr_wr` strobe or on a status read that returns 0x02.
- R4: With enable bit 2 set, any nonzero `lsr_err[3:0]` gives the line-status cause (status 0x06) in the same cycle.
- R5: Enable bit 3 latches a `msr_chg` pulse as the modem cause (status 0x00). Enable bit 4 is reserved: it always reads 0, whatever value was written.
- R6: Enable bits 5, 6 and 7 gate the Xoff (status 0x10), RTS-change and CTS-change (both status 0x20) causes. They act only while `ext_en` is 1. Otherwise their events are neither latched nor reported.
- R7: A rising or falling transition on `rts_n` or `cts_n` is latched one cycle later. A status read returning 0x20 clears both pin causes.
- R8: After reset the enable register reads 0x00, `irq` is 0 and the status reads 0x01.
- R9: While the FIFO is on and enable bits 0 to 3 are all 0, `irq` stays 0. The status register still reports pending causes.
- R10: The status register reports only the highest pending cause, in this order: line status, receive, transmit, modem, Xoff, pin change. The value 0x01 means nothing is pending, and `irq` is the inverse of status bit 0.
- R11: A status read clears only the latched cause it returns. Other pending causes stay pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (acknowledges on status) |
| host_sel | input | 1 | 0 = enable register, 1 = status register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected register |
| thr_wr | input | 1 | Host wrote the transmit holding register |
| fifo_en | input | 1 | FIFO mode active |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive trigger level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_trig | input | LVL_W | Transmit trigger level |
| rhr_full | input | 1 | Receive holding register has a byte (non-FIFO) |
| thr_empty | input | 1 | Transmit holding register empty (non-FIFO) |
| lsr_err | input | 4 | Error flags of the current receive byte |
| msr_chg | input | 1 | Modem status change pulse |
| xoff_rx | input | 1 | Received-Xoff pulse |
| ext_en | input | 1 | Extended-feature enable |
| rts_n | input | 1 | RTS pin level |
| cts_n | input | 1 | CTS pin level |
| irq | output | 1 | Interrupt request |

## Verification
The level causes (receive and line status) are combinational, so the bench checks the line and the status one settle delay after it changes an input, before the next clock edge. Latched causes (transmit, modem, Xoff, pin changes) and enable writes take effect at the first rising edge that samples them. The bench drives on a falling edge and reads on the next falling edge. A status-read acknowledge is captured in the cycle of the read and shows as cleared one cycle after it. The bench therefore reads the value during the strobe and checks the cleared state at the following falling edge.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic             host_sel,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             thr_wr,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_trig,
  input  logic             rhr_full,
  input  logic             thr_empty,
  input  logic [3:0]       lsr_err,
  input  logic             msr_chg,
  input  logic             xoff_rx,
  input  logic             ext_en,
  input  logic             rts_n,
  input  logic             cts_n,
  output logic             irq
);

  localparam logic [7:0] ID_NONE = 8'h01;
  localparam logic [7:0] ID_LINE = 8'h06;
  localparam logic [7:0] ID_RX   = 8'h04;
  localparam logic [7:0] ID_TX   = 8'h02;
  localparam logic [7:0] ID_MDM  = 8'h00;
  localparam logic [7:0] ID_XOFF = 8'h10;
  localparam logic [7:0] ID_PIN  = 8'h20;

  logic [7:0] ier, en, isr;
  logic tx_cond_q, rts_q, cts_q;
  logic tx_p, mdm_p, xoff_p, rts_p, cts_p;

  assign en = {ier[7:5] & {3{ext_en}}, 1'b0, ier[3:0]};

  wire ier_wr  = host_wr && !host_sel;
  wire isr_rd  = host_rd && host_sel;
  wire rx_src  = fifo_en ? (rx_level >= rx_trig) : rhr_full;
  wire tx_cond = fifo_en ? (tx_level < tx_trig) : thr_empty;
  wire polled  = fifo_en && (ier[3:0] == 4'h0);

  wire tx_set = (en[1] && tx_cond && !tx_cond_q) ||
                (ier_wr && host_wdata[1] && !ier[1] && tx_cond);

  always_comb begin
    if (en[2] && (|lsr_err))        isr = ID_LINE;
    else if (en[0] && rx_src)       isr = ID_RX;
    else if (en[1] && tx_p)         isr = ID_TX;
    else if (en[3] && mdm_p)        isr = ID_MDM;
    else if (en[5] && xoff_p)       isr = ID_XOFF;
    else if ((en[6] && rts_p) || (en[7] && cts_p)) isr = ID_PIN;
    else                            isr = ID_NONE;
  end

  wire ack_tx  = isr_rd && (isr == ID_TX);
  wire ack_mdm = isr_rd && (isr == ID_MDM);
  wire ack_xof = isr_rd && (isr == ID_XOFF);
  wire ack_pin = isr_rd && (isr == ID_PIN);

  assign irq        = !isr[0] && !polled;
  assign host_rdata = host_sel ? isr : ier;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier       <= 8'h00;
      tx_cond_q <= 1'b0;
      rts_q     <= 1'b1;
      cts_q     <= 1'b1;
      tx_p      <= 1'b0;
      mdm_p     <= 1'b0;
      xoff_p    <= 1'b0;
      rts_p     <= 1'b0;
      cts_p     <= 1'b0;
    end else begin
      if (ier_wr) ier <= host_wdata & 8'hEF;
      tx_cond_q <= tx_cond;
      rts_q     <= rts_n;
      cts_q     <= cts_n;
      tx_p   <= tx_set || (tx_p && !thr_wr && !ack_tx);
      mdm_p  <= (en[3] && msr_chg) || (mdm_p && !ack_mdm);
      xoff_p <= (en[5] && xoff_rx) || (xoff_p && !ack_xof);
      rts_p  <= (en[6] && (rts_n ^ rts_q)) || (rts_p && !ack_pin);
      cts_p  <= (en[7] && (cts_n ^ cts_q)) || (cts_p && !ack_pin);
    end
  end

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             host_sel,
  input logic [7:0]       host_rdata,
  input logic             fifo_en,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] rx_trig,
  input logic [3:0]       lsr_err,
  input logic             ext_en,
  input logic             rts_n,
  input logic             irq,
  input logic [7:0]       ier,
  input logic [7:0]       isr
);

  wire quiet = fifo_en && (ier[3:0] == 4'h0);

  assert_no_irq_without_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ier != 8'h00));

  assert_polled_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !irq);

  assert_line_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2] && (|lsr_err)) |-> (isr == 8'h06));

  assert_rx_trigger_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[0] && fifo_en && (rx_level >= rx_trig) && !(ier[2] && (|lsr_err)))
      |-> (isr == 8'h04));

  assert_reserved_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !host_sel |-> !host_rdata[4]);

  assert_ext_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |-> ((isr != 8'h10) && (isr != 8'h20)));

  assert_rts_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[6] && ext_en && !host_wr && (rts_n != $past(rts_n)))
      |=> (!$stable(ext_en) || (isr != 8'h01)));

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
  .host_rdata(host_rdata), .fifo_en(fifo_en), .rx_level(rx_level),
  .rx_trig(rx_trig), .lsr_err(lsr_err), .ext_en(ext_en), .rts_n(rts_n),
  .irq(irq), .ier(ier), .isr(isr)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  localparam int LW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, host_sel = 1;
  logic [7:0] host_wdata = 0, host_rdata;
  logic thr_wr = 0, fifo_en = 0, rhr_full = 0, thr_empty = 0;
  logic [LW-1:0] rx_level = 0, rx_trig = 0, tx_level = 0, tx_trig = 0;
  logic [3:0] lsr_err = 0;
  logic msr_chg = 0, xoff_rx = 0, ext_en = 0, rts_n = 1, cts_n = 1;
  logic irq;
  int checks = 0, fails = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  uart_irq_ctrl #(.LVL_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .thr_wr(thr_wr), .fifo_en(fifo_en), .rx_level(rx_level), .rx_trig(rx_trig),
    .tx_level(tx_level), .tx_trig(tx_trig), .rhr_full(rhr_full),
    .thr_empty(thr_empty), .lsr_err(lsr_err), .msr_chg(msr_chg),
    .xoff_rx(xoff_rx), .ext_en(ext_en), .rts_n(rts_n), .cts_n(cts_n), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic look(input string req, input logic [7:0] exp_isr, input logic exp_irq);
    #1;
    check(req, host_rdata, exp_isr);
    check(req, {7'd0, irq}, {7'd0, exp_irq});
  endtask

  task automatic wr_ier(input logic [7:0] d);
    @(negedge clk); host_sel = 0; host_wr = 1; host_wdata = d;
    @(negedge clk); host_wr = 0; host_sel = 1;
  endtask

  task automatic rd_isr(output logic [7:0] r);
    @(negedge clk); host_rd = 1; #1 r = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    host_sel = 0; #1;
    check("R8 enable reset", host_rdata, 8'h00);
    host_sel = 1;
    look("R8 status reset", 8'h01, 0);
    rst_n = 1;
    @(negedge clk);

    // R5 reserved bit and modem cause
    wr_ier(8'hFF); host_sel = 0; #1;
    check("R5 reserved reads 0", host_rdata, 8'hEF);
    host_sel = 1;
    wr_ier(8'h08);
    look("R5 idle", 8'h01, 0);
    pulse(msr_chg);
    look("R5 modem latched", 8'h00, 1);
    rd_isr(v); check("R5 read returns modem", v, 8'h00);
    look("R5 cleared", 8'h01, 0);

    // R1 non-FIFO receive
    wr_ier(8'h01);
    @(negedge clk); rhr_full = 1; look("R1 rhr byte", 8'h04, 1);
    rhr_full = 0; look("R1 rhr empty", 8'h01, 0);

    // R1/R2 FIFO sweep
    fifo_en = 1;
    for (int t = 1; t <= 16; t++) begin
      for (int l = 0; l <= 16; l++) begin
        @(negedge clk); rx_trig = LW'(t); rx_level = LW'(l);
        look("R1 rx trigger", (l >= t) ? 8'h04 : 8'h01, l >= t);
      end
      for (int l = 16; l >= 0; l--) begin
        @(negedge clk); rx_level = LW'(l);
        look("R2 rx self clear", (l >= t) ? 8'h04 : 8'h01, l >= t);
      end
    end
    rx_level = 0; rx_trig = 16;

    // R4 line status sweep
    wr_ier(8'h04);
    for (int e = 0; e < 16; e++) begin
      @(negedge clk); lsr_err = 4'(e);
      look("R4 line status", (e != 0) ? 8'h06 : 8'h01, e != 0);
    end
    lsr_err = 0;

    // R3 transmit, non-FIFO
    wr_ier(8'h00); fifo_en = 0; thr_empty = 0;
    wr_ier(8'h02); look("R3 not empty", 8'h01, 0);
    @(negedge clk); thr_empty = 1;
    @(negedge clk); look("R3 thr empty edge", 8'h02, 1);
    pulse(thr_wr); look("R3 thr write clears", 8'h01, 0);
    @(negedge clk); look("R3 no re-arm without edge", 8'h01, 0);

    // R3 transmit, FIFO thresholds
    wr_ier(8'h00); fifo_en = 1; tx_trig = 4; tx_level = 4;
    wr_ier(8'h02);
    @(negedge clk); look("R3 tx at trigger", 8'h01, 0);
    tx_level = 3;
    @(negedge clk); look("R3 tx below trigger", 8'h02, 1);
    rd_isr(v); check("R3 read returns tx", v, 8'h02);
    look("R3 read clears tx", 8'h01, 0);
    wr_ier(8'h00); wr_ier(8'h02);
    look("R3 enable while below", 8'h02, 1);
    pulse(thr_wr);

    // R10 / R11 priority and selective acknowledge
    wr_ier(8'h00); tx_level = 8; rx_trig = 4; rx_level = 8;
    wr_ier(8'h0F);
    lsr_err = 4'h2; pulse(msr_chg);
    tx_level = 2; @(negedge clk);
    look("R10 line highest", 8'h06, 1);
    rd_isr(v); check("R11 read line", v, 8'h06);
    lsr_err = 0; look("R10 receive next", 8'h04, 1);
    rx_level = 0; look("R10 transmit next", 8'h02, 1);
    rd_isr(v); check("R11 read tx", v, 8'h02);
    look("R11 modem still pending", 8'h00, 1);
    rd_isr(v); check("R11 read modem", v, 8'h00);
    look("R10 none pending", 8'h01, 0);
    tx_level = 8;

    // R6 / R7 extended sources
    wr_ier(8'h00); fifo_en = 0; ext_en = 0;
    wr_ier(8'hE0);
    pulse(xoff_rx);
    @(negedge clk); rts_n = 0; @(negedge clk); cts_n = 0;
    @(negedge clk); look("R6 gated off", 8'h01, 0);
    ext_en = 1;
    @(negedge clk); look("R6 nothing latched while gated", 8'h01, 0);
    pulse(xoff_rx); look("R6 xoff", 8'h10, 1);
    rd_isr(v); check("R6 read xoff", v, 8'h10);
    look("R6 xoff cleared", 8'h01, 0);
    @(negedge clk); rts_n = 1;
    @(negedge clk); look("R7 rts rising", 8'h20, 1);
    rd_isr(v); look("R7 rts cleared", 8'h01, 0);
    @(negedge clk); rts_n = 0;
    @(negedge clk); look("R7 rts falling", 8'h20, 1);
    rd_isr(v);
    @(negedge clk); cts_n = 1;
    @(negedge clk); look("R7 cts rising", 8'h20, 1);
    rd_isr(v); check("R7 read pin", v, 8'h20);
    look("R7 cts cleared", 8'h01, 0);

    // R9 polled mode
    fifo_en = 1;
    @(negedge clk); cts_n = 0;
    @(negedge clk); look("R9 polled status readable", 8'h20, 0);
    rd_isr(v); look("R9 polled cleared", 8'h01, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule